// File: doc/BRIEF.md
# Character-Cell Text Display Timing Engine

This block scans a monochrome text screen onto a raster video output. With the default parameters the screen is 80 columns by 24 rows of character cells. It runs from a single dot clock. A phase counter divides that clock into character periods of DOTS clocks. Three counters track the column, the character row and the scanline within the row. Each counter advances once per character period.

For each cell the block puts an address on a synchronous video-RAM read port. It hands the returned character code, together with the current scanline, to a synchronous glyph-ROM read port. It loads the returned glyph row into a shift register and sends it out one dot per clock. The visibility flag and the two sync flags travel down a tag pipeline of the same depth as the fetch. The enable and sync outputs therefore line up with the dots they describe.

The integrator connects two read-only memories with one clock of read latency. The reset input is held high until the clock source is stable.

Top module: `txtvid_core`

## Requirements
- R1: While reset is high, and for the first 2*DOTS clocks after it is released, de is 0, hs_n and vs_n are 1 and every colour channel is 0x00.
- R2: A character period lasts DOTS clocks. Columns count 0..COLS_TOT-1, scanlines 0..LINES-1 within a row and rows 0..ROWS_TOT-1, each wrapping to 0. Defaults: 100 columns, 20 scanlines, 26 rows, 8 dots.
- R3: For a visible cell (column < COLS_VIS, row < ROWS_VIS), vram_addr equals row*COLS_VIS + column. It holds that value for the whole character period and changes only at period boundaries.
- R4: One character period after a cell's counter period, glyph_code carries the video-RAM data returned for that cell and glyph_line carries its scanline. glyph_line never exceeds LINES-1.
- R5: The dots of a cell leave the block starting 2*DOTS clocks after the cell's counter period begins. They come out one per clock, bit DOTS-1 of the glyph row first.
- R6: A lit dot drives all ones (0xFF) on red, green and blue, and an unlit dot drives 0x00. The three channels are always equal.
- R7: de is 1 exactly while the dots of visible cells are being output, and it changes only at character-period boundaries.
- R8: While de is 0, every colour channel is 0x00, even when the glyph port returns set bits.
- R9: hs_n is low (active low) for the HS_LEN cells that start at column HS_START, on every line, aligned with the pixel output. Defaults: start 84, length 12.
- R10: vs_n is low (active low) for every cell of rows VS_START..VS_START+VS_LEN-1, aligned with the pixel output. Defaults: row 25, one row.
- R11: A reset asserted mid-frame restarts the scan at column 0, row 0, scanline 0, with the same start-up latency as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| vram_addr | output | ADDR_W | Video-RAM read address (row*COLS_VIS + column) |
| vram_data | input | CODE_W | Character code from video RAM, one clock after the address |
| glyph_code | output | CODE_W | Character code presented to the glyph ROM |
| glyph_line | output | LINE_W | Scanline presented to the glyph ROM |
| glyph_bits | input | DOTS | Glyph row from the ROM, one clock after code/line |
| red | output | COLOR_W | Red channel |
| green | output | COLOR_W | Green channel |
| blue | output | COLOR_W | Blue channel |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Display enable |

## Verification
The bench runs a reduced geometry so that a full frame and its wrap fit in a short run. It probes the edges of the visible area, the first and last cells of horizontal sync, the last scanline of a row, the vertical-sync row and the first cell of the second frame.

If the tag pipeline were one stage short or long, de and the syncs would lead or trail the dots by a whole cell, and the table entries at column boundaries would catch it. A shifter that sent the LSB first, or shifted on the load clock, would produce mirrored or skewed glyph rows. A design that did not force the colour to zero outside the visible area would leak the nonzero glyph rows that the bench ROM returns for blank cells. A mid-frame reset is checked for a clean restart at cell zero with the full start-up latency.

// File: rtl/txv_pkg.sv
package txv_pkg;

    // Default screen geometry, counted in character cells
    localparam int DEF_COLS_VIS = 80;
    localparam int DEF_COLS_TOT = 100;
    localparam int DEF_HS_START = 84;
    localparam int DEF_HS_LEN   = 12;
    localparam int DEF_ROWS_VIS = 24;
    localparam int DEF_ROWS_TOT = 26;
    localparam int DEF_VS_START = 25;
    localparam int DEF_VS_LEN   = 1;
    localparam int DEF_LINES    = 20;
    localparam int DEF_DOTS     = 8;
    localparam int DEF_CODE_W   = 8;
    localparam int DEF_COLOR_W  = 8;

    // Character stages between the counters and the shifter:
    // video-RAM fetch, then glyph fetch
    localparam int PIPE_CELLS = 2;

    // Per-cell attributes carried alongside the fetch (active high inside)
    typedef struct packed {
        logic vis;
        logic hsync;
        logic vsync;
    } cell_tag_t;

    localparam cell_tag_t TAG_IDLE = '{vis: 1'b0, hsync: 1'b0, vsync: 1'b0};

    function automatic logic in_span(input int v, input int lo, input int len);
        return (v >= lo) && (v < lo + len);
    endfunction

endpackage

// File: rtl/txv_dot_timer.sv
module txv_dot_timer #(
    parameter int DOTS = txv_pkg::DEF_DOTS
) (
    input  logic clk,
    input  logic rst,
    output logic cell_stb
);
    localparam int PH_W = (DOTS > 1) ? $clog2(DOTS) : 1;

    logic [PH_W-1:0] ph;

    assign cell_stb = (ph == PH_W'(DOTS - 1));

    generate
        if ((DOTS & (DOTS - 1)) == 0) begin : g_pow2
            // Natural binary wrap
            always_ff @(posedge clk) begin
                if (rst) ph <= '0;
                else     ph <= ph + 1'b1;
            end
        end else begin : g_mod
            always_ff @(posedge clk) begin
                if (rst)           ph <= '0;
                else if (cell_stb) ph <= '0;
                else               ph <= ph + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/txv_cell_counters.sv
module txv_cell_counters
    import txv_pkg::*;
#(
    parameter int COLS_VIS = DEF_COLS_VIS,
    parameter int COLS_TOT = DEF_COLS_TOT,
    parameter int HS_START = DEF_HS_START,
    parameter int HS_LEN   = DEF_HS_LEN,
    parameter int ROWS_VIS = DEF_ROWS_VIS,
    parameter int ROWS_TOT = DEF_ROWS_TOT,
    parameter int VS_START = DEF_VS_START,
    parameter int VS_LEN   = DEF_VS_LEN,
    parameter int LINES    = DEF_LINES,
    localparam int COL_W   = $clog2(COLS_TOT),
    localparam int ROW_W   = $clog2(ROWS_TOT),
    localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int ADDR_W  = $clog2(COLS_VIS * ROWS_VIS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_stb,
    output logic [LINE_W-1:0] line,
    output cell_tag_t         tag,
    output logic [ADDR_W-1:0] vram_addr
);
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic col_end, line_end, row_end;

    assign col_end  = (col  == COL_W'(COLS_TOT - 1));
    assign line_end = (line == LINE_W'(LINES - 1));
    assign row_end  = (row  == ROW_W'(ROWS_TOT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            col  <= '0;
            row  <= '0;
            line <= '0;
        end else if (cell_stb) begin
            if (col_end) begin
                col <= '0;
                if (line_end) begin
                    line <= '0;
                    row  <= row_end ? '0 : row + 1'b1;
                end else begin
                    line <= line + 1'b1;
                end
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    always_comb begin
        tag.vis   = (int'(col) < COLS_VIS) && (int'(row) < ROWS_VIS);
        tag.hsync = in_span(int'(col), HS_START, HS_LEN);
        tag.vsync = in_span(int'(row), VS_START, VS_LEN);
        vram_addr = tag.vis ? ADDR_W'(int'(row) * COLS_VIS + int'(col)) : '0;
    end

endmodule

// File: rtl/txv_fetch_pipe.sv
module txv_fetch_pipe
    import txv_pkg::*;
#(
    parameter int DOTS    = DEF_DOTS,
    parameter int LINE_W  = 5,
    parameter int CODE_W  = DEF_CODE_W,
    parameter int COLOR_W = DEF_COLOR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cell_stb,
    input  cell_tag_t          tag_in,
    input  logic [LINE_W-1:0]  line_in,
    input  logic [CODE_W-1:0]  vram_data,
    input  logic [DOTS-1:0]    glyph_bits,
    output logic [CODE_W-1:0]  glyph_code,
    output logic [LINE_W-1:0]  glyph_line,
    output logic [COLOR_W-1:0] red,
    output logic [COLOR_W-1:0] green,
    output logic [COLOR_W-1:0] blue,
    output logic               hs_n,
    output logic               vs_n,
    output logic               de
);
    // Tag delay line, one entry per character stage
    cell_tag_t [PIPE_CELLS-1:0] tag_q;
    cell_tag_t                  tag_out;
    logic [CODE_W-1:0]          code_q;
    logic [LINE_W-1:0]          line_q;
    logic [DOTS-1:0]            shreg;
    logic                       lit;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= {PIPE_CELLS{TAG_IDLE}};
        end else if (cell_stb) begin
            tag_q <= {tag_q[PIPE_CELLS-2:0], tag_in};
        end
    end

    // Stage 1: capture the character code and its scanline
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            line_q <= '0;
        end else if (cell_stb) begin
            code_q <= vram_data;
            line_q <= line_in;
        end
    end

    // Stage 2: load the glyph row, then shift it out MSB first
    always_ff @(posedge clk) begin
        if (rst)           shreg <= '0;
        else if (cell_stb) shreg <= glyph_bits;
        else               shreg <= {shreg[DOTS-2:0], 1'b0};
    end

    assign tag_out    = tag_q[PIPE_CELLS-1];
    assign glyph_code = code_q;
    assign glyph_line = line_q;
    assign lit        = shreg[DOTS-1] & tag_out.vis;
    assign red        = {COLOR_W{lit}};
    assign green      = {COLOR_W{lit}};
    assign blue       = {COLOR_W{lit}};
    assign de         = tag_out.vis;
    assign hs_n       = ~tag_out.hsync;
    assign vs_n       = ~tag_out.vsync;

endmodule

// File: rtl/txtvid_core.sv
module txtvid_core
    import txv_pkg::*;
#(
    parameter int COLS_VIS = DEF_COLS_VIS,
    parameter int COLS_TOT = DEF_COLS_TOT,
    parameter int HS_START = DEF_HS_START,
    parameter int HS_LEN   = DEF_HS_LEN,
    parameter int ROWS_VIS = DEF_ROWS_VIS,
    parameter int ROWS_TOT = DEF_ROWS_TOT,
    parameter int VS_START = DEF_VS_START,
    parameter int VS_LEN   = DEF_VS_LEN,
    parameter int LINES    = DEF_LINES,
    parameter int DOTS     = DEF_DOTS,
    parameter int CODE_W   = DEF_CODE_W,
    parameter int COLOR_W  = DEF_COLOR_W,
    localparam int LINE_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int ADDR_W  = $clog2(COLS_VIS * ROWS_VIS)
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  vram_addr,
    input  logic [CODE_W-1:0]  vram_data,
    output logic [CODE_W-1:0]  glyph_code,
    output logic [LINE_W-1:0]  glyph_line,
    input  logic [DOTS-1:0]    glyph_bits,
    output logic [COLOR_W-1:0] red,
    output logic [COLOR_W-1:0] green,
    output logic [COLOR_W-1:0] blue,
    output logic               hs_n,
    output logic               vs_n,
    output logic               de
);
    logic              cell_stb;
    logic [LINE_W-1:0] cur_line;
    cell_tag_t         cur_tag;

    txv_dot_timer #(.DOTS(DOTS)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .cell_stb (cell_stb)
    );

    txv_cell_counters #(
        .COLS_VIS (COLS_VIS),
        .COLS_TOT (COLS_TOT),
        .HS_START (HS_START),
        .HS_LEN   (HS_LEN),
        .ROWS_VIS (ROWS_VIS),
        .ROWS_TOT (ROWS_TOT),
        .VS_START (VS_START),
        .VS_LEN   (VS_LEN),
        .LINES    (LINES)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .cell_stb  (cell_stb),
        .line      (cur_line),
        .tag       (cur_tag),
        .vram_addr (vram_addr)
    );

    txv_fetch_pipe #(
        .DOTS    (DOTS),
        .LINE_W  (LINE_W),
        .CODE_W  (CODE_W),
        .COLOR_W (COLOR_W)
    ) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .cell_stb   (cell_stb),
        .tag_in     (cur_tag),
        .line_in    (cur_line),
        .vram_data  (vram_data),
        .glyph_bits (glyph_bits),
        .glyph_code (glyph_code),
        .glyph_line (glyph_line),
        .red        (red),
        .green      (green),
        .blue       (blue),
        .hs_n       (hs_n),
        .vs_n       (vs_n),
        .de         (de)
    );

endmodule

// File: rtl/txv_checker.sv
module txv_checker #(
    parameter int DOTS     = 8,
    parameter int LINES    = 20,
    parameter int COLS_VIS = 80,
    parameter int ROWS_VIS = 24,
    parameter int ADDR_W   = 11,
    parameter int LINE_W   = 5,
    parameter int COLOR_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  vram_addr,
    input logic [LINE_W-1:0]  glyph_line,
    input logic [COLOR_W-1:0] red,
    input logic [COLOR_W-1:0] green,
    input logic [COLOR_W-1:0] blue,
    input logic               hs_n,
    input logic               vs_n,
    input logic               de
);
    localparam int CPH_W = (DOTS > 1) ? $clog2(DOTS) : 1;

    // Checker's own dot phase, counted from reset release
    logic [CPH_W-1:0] cph;

    always_ff @(posedge clk) begin
        if (rst)                              cph <= '0;
        else if (cph == CPH_W'(DOTS - 1))     cph <= '0;
        else                                  cph <= cph + 1'b1;
    end

    p_addr_cell_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(vram_addr) |-> (cph == '0));

    p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
        int'(vram_addr) < COLS_VIS * ROWS_VIS);

    p_line_range_r4: assert property (@(posedge clk) disable iff (rst)
        int'(glyph_line) < LINES);

    p_rgb_levels_r6: assert property (@(posedge clk) disable iff (rst)
        (red == '0 || red == '1) && (green == red) && (blue == red));

    p_de_cell_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(de) |-> (cph == '0));

    p_dark_when_blank_r8: assert property (@(posedge clk) disable iff (rst)
        !de |-> (red == '0));

    p_hsync_in_blank_r9: assert property (@(posedge clk) disable iff (rst)
        !hs_n |-> !de);

    p_vsync_in_blank_r10: assert property (@(posedge clk) disable iff (rst)
        !vs_n |-> !de);

endmodule

bind txtvid_core txv_checker #(
    .DOTS     (DOTS),
    .LINES    (LINES),
    .COLS_VIS (COLS_VIS),
    .ROWS_VIS (ROWS_VIS),
    .ADDR_W   (ADDR_W),
    .LINE_W   (LINE_W),
    .COLOR_W  (COLOR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .vram_addr  (vram_addr),
    .glyph_line (glyph_line),
    .red        (red),
    .green      (green),
    .blue       (blue),
    .hs_n       (hs_n),
    .vs_n       (vs_n),
    .de         (de)
);

// File: tb/txtvid_core_test.sv
module txtvid_core_test;

    // Reduced geometry so a whole frame fits in a short run
    localparam int CV = 10, CT = 14, HSS = 11, HSL = 2;
    localparam int RV = 3,  RT = 5,  VSS = 4,  VSL = 1;
    localparam int LN = 4,  DT = 8;
    localparam int FRAME = CT * LN * RT;
    localparam int AW = $clog2(CV * RV);
    localparam int LW = $clog2(LN);

    // Probe cells: global cell index, expected de, hs_n, vs_n
    localparam int NP = 16;
    localparam int PROBE [NP][4] = '{
        '{0,   1, 1, 1}, '{9,   1, 1, 1}, '{10,  0, 1, 1}, '{11,  0, 0, 1},
        '{12,  0, 0, 1}, '{13,  0, 1, 1}, '{14,  1, 1, 1}, '{55,  0, 1, 1},
        '{56,  1, 1, 1}, '{167, 0, 1, 1}, '{177, 0, 1, 1}, '{224, 0, 1, 0},
        '{235, 0, 0, 0}, '{279, 0, 1, 0}, '{280, 1, 1, 1}, '{289, 1, 1, 1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] vram_addr;
    logic [7:0]    vram_data;
    logic [7:0]    glyph_code;
    logic [LW-1:0] glyph_line;
    logic [7:0]    glyph_bits;
    logic [7:0]    red, green, blue;
    logic          hs_n, vs_n, de;

    int checks = 0;
    int fails  = 0;
    int ecount = 0;

    always #10 clk = ~clk;

    txtvid_core #(
        .COLS_VIS (CV), .COLS_TOT (CT), .HS_START (HSS), .HS_LEN (HSL),
        .ROWS_VIS (RV), .ROWS_TOT (RT), .VS_START (VSS), .VS_LEN (VSL),
        .LINES (LN), .DOTS (DT), .CODE_W (8), .COLOR_W (8)
    ) uut (
        .clk (clk), .rst (rst),
        .vram_addr (vram_addr), .vram_data (vram_data),
        .glyph_code (glyph_code), .glyph_line (glyph_line), .glyph_bits (glyph_bits),
        .red (red), .green (green), .blue (blue),
        .hs_n (hs_n), .vs_n (vs_n), .de (de)
    );

    function automatic logic [7:0] code_of(input int a);
        return 8'(a * 37 + 11);
    endfunction

    function automatic logic [7:0] glyph_of(input logic [7:0] c, input int ln);
        return c ^ 8'(ln * 73 + 5);
    endfunction

    // Memory models: one clock of read latency each
    always @(posedge clk) vram_data  <= code_of(int'(vram_addr));
    always @(posedge clk) glyph_bits <= glyph_of(glyph_code, int'(glyph_line));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Advance to just after clock edge e (counted from reset release)
    task automatic step_to(input int e);
        if (ecount < e) begin
            while (ecount < e) begin
                @(posedge clk);
                ecount++;
            end
            @(negedge clk);
        end
    endtask

    task automatic probe(input int k, input int ede, input int ehs, input int evs);
        int f = k % FRAME;
        int c = f % CT;
        int l = (f / CT) % LN;
        int r = (f / CT) / LN;
        bit vis = (c < CV) && (r < RV);
        int a = r * CV + c;
        logic [7:0] g = glyph_of(code_of(a), l);
        if (ecount < 8 * k + 2) begin
            step_to(8 * k + 2);
            if (vis) check(int'(vram_addr) == a, "R3", "video address", int'(vram_addr), a);
            if (k > 0 && f == 0)
                check(int'(vram_addr) == 0 && vis, "R2", "frame wrap address", int'(vram_addr), 0);
        end
        if (ecount < 8 * k + 10) begin
            step_to(8 * k + 10);
            if (vis) check(glyph_code == code_of(a), "R4", "glyph code",
                           int'(glyph_code), int'(code_of(a)));
            check(int'(glyph_line) == l, "R4", "glyph scanline", int'(glyph_line), l);
        end
        for (int j = 0; j < DT; j++) begin
            int exp;
            step_to(8 * k + 16 + j);
            if (j == 0) begin
                check(int'(de) == ede,   "R7",  "display enable", int'(de), ede);
                check(int'(hs_n) == ehs, "R9",  "horizontal sync", int'(hs_n), ehs);
                check(int'(vs_n) == evs, "R10", "vertical sync", int'(vs_n), evs);
            end
            exp = (ede != 0 && g[DT-1-j]) ? 255 : 0;
            check(int'(red) == exp, (ede != 0) ? "R5" : "R8", "dot level", int'(red), exp);
            check(green == red && blue == red, "R6", "channel match", int'(blue), int'(red));
        end
    endtask

    initial begin
        // R1: state held during reset
        repeat (4) @(negedge clk);
        check(de == 1'b0 && red == 8'h00, "R1", "de/rgb in reset", int'(de), 0);
        check(hs_n && vs_n, "R1", "syncs in reset", int'({hs_n, vs_n}), 3);
        rst = 1'b0;
        ecount = 0;

        // Table walk over one frame and into the next (R2, R3..R10)
        for (int i = 0; i < NP; i++)
            probe(PROBE[i][0], PROBE[i][1], PROBE[i][2], PROBE[i][3]);

        // R11: reset in mid-frame, then restart latency (R1)
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(de == 1'b0 && hs_n && vs_n, "R11", "outputs during mid reset", int'(de), 0);
        rst = 1'b0;
        ecount = 0;
        step_to(2);
        check(int'(vram_addr) == 0, "R11", "address after restart", int'(vram_addr), 0);
        step_to(12);
        check(de == 1'b0 && red == 8'h00, "R1", "output before first cell", int'(de), 0);
        check(hs_n && vs_n, "R1", "syncs before first cell", int'({hs_n, vs_n}), 3);
        step_to(16);
        check(de == 1'b1, "R11", "first cell enable", int'(de), 1);
        begin
            logic [7:0] g0 = glyph_of(code_of(0), 0);
            int e0 = g0[DT-1] ? 255 : 0;
            check(int'(red) == e0, "R11", "first dot after restart", int'(red), e0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", ecount, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule